// File: doc/BRIEF.md
# Second-Chance Victim Way Selector

This block chooses which way of a set-associative cache set gets evicted on a miss. It uses the second-chance (clock) scheme. Each way of each set carries a single "recently touched" flag, and each set has a rotating pointer to its oldest candidate. Every cache hit or fill reports its (set, way) on the access strobe, which raises that way's flag.

When the cache controller needs a victim, it presents the set on the victim request. The selector then walks that set's ways one per clock cycle, starting at the pointer. A way whose flag is raised loses the flag and is passed over. The first way found with a clear flag becomes the victim. It is returned together with a one-cycle done pulse. The selector also raises the flag of the chosen way, because that way is about to be refilled, and moves the set's pointer one step past it. Only one victim search runs at a time.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every flag and every pointer is zero and `victim_done` is low. The first victim request to any set therefore returns way 0 after one check.
- R2: A cycle with `acc_valid` high raises the flag of way `acc_way` in set `acc_set`. Later searches of that set skip this way once.
- R3: A victim request is sampled on a clock edge while the selector is idle. Checking starts at the set's pointer on the next edge and covers one way per edge. `victim_done` goes high right after the edge of the final check, so the latency in cycles equals the number of ways checked.
- R4: A checked way whose flag is raised has the flag cleared, and the search moves on to the next way. After way NUM_WAYS-1 the search wraps to way 0.
- R5: The victim is the first checked way whose flag is clear. `victim_way` carries it while `victim_done` is high. `victim_done` is a one-cycle pulse and `victim_way` is below NUM_WAYS.
- R6: After a victim is chosen, the set's pointer moves to the victim plus one, modulo NUM_WAYS.
- R7: If every flag in the set is raised, the search clears all of them and returns the way at the starting pointer after exactly NUM_WAYS+1 checks.
- R8: The chosen victim's flag is raised when it is returned, because that way is being refilled.
- R9: Sets are independent. Accesses and searches in one set leave the flags and pointer of every other set unchanged. An access to another set is applied even while a search runs.
- R10: A victim request that arrives while a search is in progress is ignored. It produces no extra done pulse and changes no state of its set.
- R11: With NUM_WAYS = 1, every victim is way 0. The first search of a set takes one check and each later search takes two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | SET_W | Set of the access |
| acc_way | input | WAY_W | Way of the access |
| vreq_valid | input | 1 | Victim request strobe |
| vreq_set | input | SET_W | Set needing a victim |
| victim_way | output | WAY_W | Chosen way, valid with victim_done |
| victim_done | output | 1 | One-cycle pulse marking a chosen victim |

## Verification
The bench targets the full-wrap case where every flag in the set is raised. A design that stops one way early, or that forgets to clear flags, would return the wrong way or never finish. Pointer wrap from the last way back to way 0 is checked, because an off-by-one pointer would repeat or skip a way. The bench also drives a second request while a search is in flight, and a design that accepts it would emit a second pulse or move another set's pointer. Finally it covers the single-way configuration and searches run back to back in one set. A design that skips raising the refilled way's flag would there show one-check searches where two are expected.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             vreq_valid,
  input  logic [SET_W-1:0] vreq_set,
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_done
);

  logic [NUM_SETS-1:0][NUM_WAYS-1:0] ref_q;
  logic [NUM_SETS-1:0][WAY_W-1:0]    hand_q;
  logic                              busy_q;
  logic [SET_W-1:0]                  set_q;
  logic [WAY_W-1:0]                  ptr_q;

  logic [WAY_W-1:0] ptr_nxt;
  logic             cur_ref;
  logic             acc_ok;

  assign ptr_nxt = (ptr_q == WAY_W'(NUM_WAYS - 1)) ? '0 : ptr_q + 1'b1;
  assign cur_ref = ref_q[set_q][ptr_q];
  assign acc_ok  = acc_valid
                && ({1'b0, acc_way} < (WAY_W+1)'(NUM_WAYS))
                && ({1'b0, acc_set} < (SET_W+1)'(NUM_SETS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q       <= '0;
      hand_q      <= '0;
      busy_q      <= 1'b0;
      set_q       <= '0;
      ptr_q       <= '0;
      victim_way  <= '0;
      victim_done <= 1'b0;
    end else begin
      victim_done <= 1'b0;
      if (!busy_q) begin
        if (vreq_valid && ({1'b0, vreq_set} < (SET_W+1)'(NUM_SETS))) begin
          busy_q <= 1'b1;
          set_q  <= vreq_set;
          ptr_q  <= hand_q[vreq_set];
        end
      end else if (cur_ref) begin
        ref_q[set_q][ptr_q] <= 1'b0;
        ptr_q               <= ptr_nxt;
      end else begin
        ref_q[set_q][ptr_q] <= 1'b1;
        hand_q[set_q]       <= ptr_nxt;
        victim_way          <= ptr_q;
        victim_done         <= 1'b1;
        busy_q              <= 1'b0;
      end
      if (acc_ok)
        ref_q[acc_set][acc_way] <= 1'b1;
    end
  end

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              busy_q,
  input logic [SET_W-1:0]                  set_q,
  input logic                              victim_done,
  input logic [WAY_W-1:0]                  victim_way,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0] ref_q,
  input logic [NUM_SETS-1:0][WAY_W-1:0]    hand_q
);

  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_cnt <= 0;
    else if (busy_q) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |=> !victim_done);

  assert_way_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |-> ({1'b0, victim_way} < (WAY_W+1)'(NUM_WAYS)));

  assert_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |-> !busy_q);

  assert_search_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= NUM_WAYS + 1);

  assert_refill_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |-> ref_q[set_q][victim_way]);

  assert_hand_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |-> hand_q[set_q] ==
      ((victim_way == WAY_W'(NUM_WAYS - 1)) ? '0 : victim_way + 1'b1));

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_q(busy_q), .set_q(set_q),
  .victim_done(victim_done), .victim_way(victim_way),
  .ref_q(ref_q), .hand_q(hand_q)
);

// File: tb/clock_victim_sel_tb.sv
`timescale 1ns/1ps
module clock_victim_sel_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       acc = 1'b0, vq = 1'b0, dn;
  logic [3:0] as = '0, vs = '0;
  logic [1:0] aw = '0, vw;

  logic       vq1 = 1'b0, dn1;
  logic [3:0] vs1 = '0;
  logic       vw1;

  clock_victim_sel #(.NUM_SETS(16), .NUM_WAYS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc), .acc_set(as), .acc_way(aw),
    .vreq_valid(vq), .vreq_set(vs), .victim_way(vw), .victim_done(dn));

  clock_victim_sel #(.NUM_SETS(16), .NUM_WAYS(1)) u_dut_w1 (
    .clk(clk), .rst_n(rst_n), .acc_valid(1'b0), .acc_set(4'd0), .acc_way(1'b0),
    .vreq_valid(vq1), .vreq_set(vs1), .victim_way(vw1), .victim_done(dn1));

  int nchk = 0, nfail = 0, cyc = 0;

  // {op(1:victim,0:access), set(4), way(2), exp_way(2), exp_checks(4)}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 4'd3, 2'd0, 2'd0, 4'd1},
    {1'b1, 4'd3, 2'd0, 2'd1, 4'd1},
    {1'b0, 4'd3, 2'd2, 2'd0, 4'd0},
    {1'b0, 4'd3, 2'd3, 2'd0, 4'd0},
    {1'b1, 4'd3, 2'd0, 2'd2, 4'd5},
    {1'b1, 4'd3, 2'd0, 2'd3, 4'd1},
    {1'b1, 4'd3, 2'd0, 2'd0, 4'd1},
    {1'b0, 4'd3, 2'd1, 2'd0, 4'd0},
    {1'b1, 4'd3, 2'd0, 2'd1, 4'd5},
    {1'b1, 4'd5, 2'd0, 2'd0, 4'd1},
    {1'b0, 4'd3, 2'd2, 2'd0, 4'd0},
    {1'b1, 4'd3, 2'd0, 2'd3, 4'd2},
    {1'b1, 4'd3, 2'd0, 2'd0, 4'd1},
    {1'b1, 4'd3, 2'd0, 2'd2, 4'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input int s, input int w);
    @(negedge clk);
    acc = 1'b1; as = 4'(s); aw = 2'(w);
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic do_victim(input bit one, input int s, output int way, output int n);
    @(negedge clk);
    if (one) begin vq1 = 1'b1; vs1 = 4'(s); end
    else     begin vq  = 1'b1; vs  = 4'(s); end
    @(negedge clk);
    vq = 1'b0; vq1 = 1'b0; n = 0;
    do begin @(negedge clk); n++; end while (!(one ? dn1 : dn) && n < 40);
    way = one ? int'(vw1) : int'(vw);
    @(negedge clk);
    chk("R5 done pulse one cycle", one ? int'(dn1) : int'(dn), 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    int w, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done low after reset", int'(dn), 0);
    chk("R1 done low after reset (1 way)", int'(dn1), 0);

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      if (v[12]) begin
        do_victim(1'b0, int'(v[11:8]), w, n);
        chk("R5 victim way", w, int'(v[5:4]));
        if (v[3:0] == 4'd5)      chk("R7 checks on full wrap", n, 5);
        else if (v[3:0] > 4'd1)  chk("R4 checks with skips", n, int'(v[3:0]));
        else                     chk("R3 R6 single-check latency", n, 1);
      end else begin
        do_access(int'(v[11:8]), int'(v[7:6])); // R2
      end
    end

    // R9: access to set 7 in the same cycle a search of set 3 starts
    @(negedge clk);
    vq = 1'b1; vs = 4'd3; acc = 1'b1; as = 4'd7; aw = 2'd0;
    @(negedge clk);
    vq = 1'b0; acc = 1'b0; n = 0;
    do begin @(negedge clk); n++; end while (!dn && n < 40);
    chk("R4 wrap past last way", int'(vw), 1);
    chk("R4 checks across wrap", n, 3);
    do_victim(1'b0, 7, w, n);
    chk("R9 other-set access applied", w, 1);
    chk("R9 other-set checks", n, 2);

    // R10: set-6 request during a busy search of set 3
    @(negedge clk);
    vq = 1'b1; vs = 4'd3;
    @(negedge clk);
    vs = 4'd6;
    @(negedge clk);
    vq = 1'b0;
    chk("R10 no done mid-search", int'(dn), 0);
    @(negedge clk);
    chk("R10 first search completes", int'(dn), 1);
    chk("R10 first search way", int'(vw), 3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 no extra done", int'(dn), 0);
    end
    do_victim(1'b0, 6, w, n);
    chk("R10 ignored request left set 6 untouched", w, 0);
    chk("R10 set 6 checks", n, 1);

    // R11 / R8: single-way configuration
    do_victim(1'b1, 2, w, n);
    chk("R11 single way victim", w, 0);
    chk("R11 first search checks", n, 1);
    do_victim(1'b1, 2, w, n);
    chk("R11 single way victim again", w, 0);
    chk("R8 refilled flag forces two checks", n, 2);

    // R1: reset clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 done low in reset", int'(dn), 0);
    rst_n = 1'b1;
    do_victim(1'b0, 3, w, n);
    chk("R1 way 0 after reset", w, 0);
    chk("R1 one check after reset", n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule